// File: doc/BRIEF.md
# Power-Gate Release Sequencer

This block is a small bus master that releases a graphics engine which the chip holds power-gated after boot. A single start pulse launches a fixed program of sixteen steps that touches three control registers: an engine control register, a power-switch clamp register and a gating override register. Each field change is done as a read followed by a write of the same word with only the target bit altered. The program also holds two long settle pauses whose length is a parameter in clock cycles. For 50 ms at 100 MHz the value is 5,000,000, and a bench may choose a much smaller one.

The bus side has an address, write data, read data, one read strobe, one write strobe and a ready input. A strobe and its address stay asserted until ready is sampled high on a rising clock edge. Read data is taken on that same edge. The block raises busy while the program runs and gives a one-cycle done pulse when the closing read completes.

The state machine has five states. S_IDLE waits for start. S_READ holds the read strobe. S_WRITE holds the write strobe with the merged word. S_WAIT runs the settle timer. S_DONE is the one-cycle completion state, and like S_IDLE it accepts a new start. The transitions are as follows. Start moves S_IDLE or S_DONE to S_READ. A completed read of a field-update step moves S_READ to S_WRITE. A completed plain read, a completed write or an expired timer moves to the entry state of the next step: S_WAIT for a pause and S_READ otherwise. After the last step the machine moves to S_DONE. S_DONE returns to S_IDLE when no start is present.

Top module: `pg_release_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, bus_rd, bus_wr, busy and done are all 0.
- R2: A start sampled high in the idle or done state makes busy 1 from the next cycle, and the first bus access is a read of address 0x200.
- R3: Once bus_rd or bus_wr is raised, it stays high with an unchanged bus_addr until bus_ready is sampled high. Read data is captured on that ready edge.
- R4: Every field update reads the register and then writes the same address. The written word equals the word read with only the one target bit replaced, so every other bit is preserved.
- R5: The access order is fixed. First bit 12 of 0x200 is cleared, 0x200 is read, bit 27 of 0x200 is set, and the first pause follows. Next, at 0x10a78c, bit 1 is set to 1, then bit 0 is set to 1 and cleared to 0. Then, at 0x20004, bit 31 is cleared and bit 30 is set, and the second pause follows. Next, bit 1 of 0x10a78c is cleared to 0 and bit 0 is set to 1 and cleared to 0. Bit 27 of 0x200 is then cleared, bit 12 of 0x200 is set, and a final read of 0x200 closes the run.
- R6: Each of the two pauses lasts exactly WAIT_CYCLES clock cycles, with busy high and neither strobe asserted.
- R7: done is high for exactly one cycle, in the cycle after the final read completes. busy falls in that same cycle.
- R8: A start that arrives while busy is high has no effect. It neither adds bus accesses nor changes their order, and it raises no extra done pulse.
- R9: bus_rd and bus_wr are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, taken only when not busy |
| bus_addr | output | 32 | Address of the current access |
| bus_wdata | output | 32 | Merged word for the current write |
| bus_rdata | input | 32 | Read data, valid while bus_ready is high |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_ready | input | 1 | Access completes on an edge where this is high |
| busy | output | 1 | Program in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is a start pulse that lands in the middle of a run. It is most telling when it lands during a settle pause, where no strobe is active and nothing on the bus would show that it was swallowed. The bench runs the program twice against a responding register model. On the second run it pulses start both during the first pause and during an access that ready holds back. The scoreboard must then find exactly the expected accesses, no extra ones, exactly one done pulse and exactly two full pauses. The register model's ready delays rotate through 0 to 3 cycles, so every strobe is held across stalls of varying length.

// File: rtl/pgr_pkg.sv
package pgr_pkg;
    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 32;
    localparam int STEP_COUNT = 16;
    localparam int STEP_W     = $clog2(STEP_COUNT);
    localparam int BIT_W      = $clog2(DATA_W);

    localparam logic [ADDR_W-1:0] ENG_CTRL_ADDR  = 32'h0000_0200;
    localparam logic [ADDR_W-1:0] CLAMP_CTL_ADDR = 32'h0010_a78c;
    localparam logic [ADDR_W-1:0] GATE_OVR_ADDR  = 32'h0002_0004;

    localparam int ENG_RUN_BIT   = 12;
    localparam int BLK_GATE_BIT  = 27;
    localparam int CLAMP_MSK_BIT = 0;
    localparam int CLAMP_VAL_BIT = 1;
    localparam int OVR_EN_BIT    = 30;
    localparam int OVR_VAL_BIT   = 31;

    typedef enum logic [1:0] {OP_RMW, OP_READ, OP_WAIT} op_e;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [BIT_W-1:0]  bitpos;
        logic              val;
    } step_t;

    function automatic step_t mk_step(op_e op, logic [ADDR_W-1:0] addr, int bitpos, logic val);
        step_t s;
        s.op     = op;
        s.addr   = addr;
        s.bitpos = BIT_W'(bitpos);
        s.val    = val;
        return s;
    endfunction
endpackage

// File: rtl/pgr_step_rom.sv
module pgr_step_rom
    import pgr_pkg::*;
(
    input  logic [STEP_W-1:0] idx,
    output step_t             step
);
    always_comb begin
        unique case (idx)
            4'd0:  step = mk_step(OP_RMW,  ENG_CTRL_ADDR,  ENG_RUN_BIT,   1'b0);
            4'd1:  step = mk_step(OP_READ, ENG_CTRL_ADDR,  0,             1'b0);
            4'd2:  step = mk_step(OP_RMW,  ENG_CTRL_ADDR,  BLK_GATE_BIT,  1'b1);
            4'd3:  step = mk_step(OP_WAIT, ENG_CTRL_ADDR,  0,             1'b0);
            4'd4:  step = mk_step(OP_RMW,  CLAMP_CTL_ADDR, CLAMP_VAL_BIT, 1'b1);
            4'd5:  step = mk_step(OP_RMW,  CLAMP_CTL_ADDR, CLAMP_MSK_BIT, 1'b1);
            4'd6:  step = mk_step(OP_RMW,  CLAMP_CTL_ADDR, CLAMP_MSK_BIT, 1'b0);
            4'd7:  step = mk_step(OP_RMW,  GATE_OVR_ADDR,  OVR_VAL_BIT,   1'b0);
            4'd8:  step = mk_step(OP_RMW,  GATE_OVR_ADDR,  OVR_EN_BIT,    1'b1);
            4'd9:  step = mk_step(OP_WAIT, GATE_OVR_ADDR,  0,             1'b0);
            4'd10: step = mk_step(OP_RMW,  CLAMP_CTL_ADDR, CLAMP_VAL_BIT, 1'b0);
            4'd11: step = mk_step(OP_RMW,  CLAMP_CTL_ADDR, CLAMP_MSK_BIT, 1'b1);
            4'd12: step = mk_step(OP_RMW,  CLAMP_CTL_ADDR, CLAMP_MSK_BIT, 1'b0);
            4'd13: step = mk_step(OP_RMW,  ENG_CTRL_ADDR,  BLK_GATE_BIT,  1'b0);
            4'd14: step = mk_step(OP_RMW,  ENG_CTRL_ADDR,  ENG_RUN_BIT,   1'b1);
            default: step = mk_step(OP_READ, ENG_CTRL_ADDR, 0,            1'b0);
        endcase
    end
endmodule

// File: rtl/pgr_wait_timer.sv
module pgr_wait_timer #(
    parameter int WAIT_CYCLES = 5_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = $clog2(WAIT_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run || expired) cnt_q <= '0;
        else                        cnt_q <= cnt_q + 1'b1;
    end

    assign expired = run && (cnt_q == LAST);

    // R6: the count never passes the programmed pause length
    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);
endmodule

// File: rtl/pg_release_seq.sv
module pg_release_seq
    import pgr_pkg::*;
#(
    parameter int WAIT_CYCLES = 5_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rd,
    output logic              bus_wr,
    input  logic              bus_ready,
    output logic              busy,
    output logic              done
);
    typedef enum logic [2:0] {S_IDLE, S_READ, S_WRITE, S_WAIT, S_DONE} state_e;

    state_e            state_q;
    logic [STEP_W-1:0] step_q;
    logic [STEP_W-1:0] ahead_idx;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] merged;
    step_t             cur_step;
    step_t             ahead_step;
    state_e            adv_state;
    logic              last_step;
    logic              timer_expired;
    logic              idle_like;

    function automatic state_e entry_state(op_e op);
        return (op == OP_WAIT) ? S_WAIT : S_READ;
    endfunction

    pgr_step_rom u_rom_cur   (.idx(step_q),    .step(cur_step));
    pgr_step_rom u_rom_ahead (.idx(ahead_idx), .step(ahead_step));

    pgr_wait_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (state_q == S_WAIT),
        .expired (timer_expired)
    );

    always_comb begin
        idle_like = (state_q == S_IDLE) || (state_q == S_DONE);
        last_step = (step_q == STEP_W'(STEP_COUNT - 1));
        ahead_idx = idle_like ? '0 : step_q + 1'b1;
        adv_state = last_step ? S_DONE : entry_state(ahead_step.op);
        merged    = bus_rdata;
        merged[cur_step.bitpos] = cur_step.val;
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            step_q  <= '0;
            wdata_q <= '0;
        end else begin
            unique case (state_q)
                S_IDLE, S_DONE: begin
                    if (start) begin
                        step_q  <= '0;
                        state_q <= entry_state(ahead_step.op);
                    end else begin
                        state_q <= S_IDLE;
                    end
                end
                S_READ: begin
                    if (bus_ready) begin
                        if (cur_step.op == OP_RMW) begin
                            wdata_q <= merged;
                            state_q <= S_WRITE;
                        end else begin
                            state_q <= adv_state;
                            if (!last_step) step_q <= step_q + 1'b1;
                        end
                    end
                end
                S_WRITE: begin
                    if (bus_ready) begin
                        state_q <= adv_state;
                        if (!last_step) step_q <= step_q + 1'b1;
                    end
                end
                S_WAIT: begin
                    if (timer_expired) begin
                        state_q <= adv_state;
                        if (!last_step) step_q <= step_q + 1'b1;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        bus_rd    = (state_q == S_READ);
        bus_wr    = (state_q == S_WRITE);
        bus_addr  = cur_step.addr;
        bus_wdata = wdata_q;
        busy      = !idle_like;
        done      = (state_q == S_DONE);
    end

    assert_one_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && bus_wr));

    assert_strobe_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_rd || bus_wr) && !bus_ready |=>
            (bus_rd == $past(bus_rd)) && (bus_wr == $past(bus_wr)) && $stable(bus_addr));

    assert_write_after_read_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_wr) |-> $past(bus_rd && bus_ready) && $stable(bus_addr));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_busy_fall_done_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);
endmodule

// File: tb/sim_pg_release_seq.sv
module sim_pg_release_seq;
    localparam int W = 20;

    typedef struct {
        bit          is_wr;
        logic [31:0] addr;
        logic [31:0] data;
    } item_t;

    logic        clk = 0;
    logic        rst = 1;
    logic        start = 0;
    logic [31:0] bus_addr, bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic        bus_rd, bus_wr;
    logic        bus_ready = 0;
    logic        busy, done;

    int checks = 0;
    int errors = 0;
    item_t exp_q[$];
    logic [31:0] mem [3];
    logic [31:0] sh [3];
    int  done_cnt = 0;
    int  wait_cyc = 0;
    int  both_cnt = 0;
    bit  prev_done = 0;

    always #5 clk = ~clk;

    pg_release_seq #(.WAIT_CYCLES(W)) u0 (
        .clk(clk), .rst(rst), .start(start),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_ready(bus_ready),
        .busy(busy), .done(done)
    );

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int slot(logic [31:0] a);
        case (a)
            32'h0000_0200: return 0;
            32'h0010_a78c: return 1;
            32'h0002_0004: return 2;
            default:       return -1;
        endcase
    endfunction

    // driver side: expected items
    task automatic exp_read(logic [31:0] a);
        item_t it;
        it.is_wr = 0; it.addr = a; it.data = sh[slot(a)];
        exp_q.push_back(it);
    endtask

    task automatic exp_rmw(logic [31:0] a, int b, bit v);
        item_t it;
        exp_read(a);
        sh[slot(a)][b] = v;
        it.is_wr = 1; it.addr = a; it.data = sh[slot(a)];
        exp_q.push_back(it);
    endtask

    task automatic push_program();
        exp_rmw(32'h200, 12, 0);
        exp_read(32'h200);
        exp_rmw(32'h200, 27, 1);
        exp_rmw(32'h10a78c, 1, 1);
        exp_rmw(32'h10a78c, 0, 1);
        exp_rmw(32'h10a78c, 0, 0);
        exp_rmw(32'h20004, 31, 0);
        exp_rmw(32'h20004, 30, 1);
        exp_rmw(32'h10a78c, 1, 0);
        exp_rmw(32'h10a78c, 0, 1);
        exp_rmw(32'h10a78c, 0, 0);
        exp_rmw(32'h200, 27, 0);
        exp_rmw(32'h200, 12, 1);
        exp_read(32'h200);
    endtask

    // register model and monitor
    bit          rdy_pend = 0;
    bit          pend_wr = 0;
    int          pend_slot = 0;
    logic [31:0] pend_data = '0;
    int          stall = 0;
    int          stall_seed = 0;
    bit          hold_pend = 0;
    bit          hold_rd = 0, hold_wr = 0;
    logic [31:0] hold_addr = '0;

    always @(negedge clk) begin
        if (!rst) begin
            if (bus_rd && bus_wr) both_cnt++;
            if (busy && !bus_rd && !bus_wr) wait_cyc++;
            if (done) begin
                done_cnt++;
                chk(!busy, "R7", "busy low while done", 32'(busy), 0);
            end
            if (done && prev_done) chk(0, "R7", "done wider than one cycle", 1, 0);
            prev_done = done;

            if (hold_pend) begin
                hold_pend = 0;
                chk(bus_rd == hold_rd && bus_wr == hold_wr && bus_addr == hold_addr,
                    "R3", "strobe/address held during stall", bus_addr, hold_addr);
            end

            if (rdy_pend) begin
                if (pend_wr) mem[pend_slot] = pend_data;
                rdy_pend  = 0;
                bus_ready = 0;
                stall_seed++;
                stall = stall_seed % 4;
            end else if (bus_rd || bus_wr) begin
                if (stall == 0) begin
                    item_t it;
                    int s;
                    s = slot(bus_addr);
                    if (exp_q.size() == 0) begin
                        chk(0, "R8", "unexpected bus access", bus_addr, 0);
                    end else begin
                        it = exp_q.pop_front();
                        chk(it.is_wr == bus_wr && it.addr == bus_addr, "R5",
                            bus_wr ? "write kind/address" : "read kind/address",
                            bus_addr, it.addr);
                        if (bus_wr)
                            chk(bus_wdata == it.data, "R4", "merged write data", bus_wdata, it.data);
                    end
                    if (s < 0) s = 0;
                    bus_rdata = mem[s];
                    pend_wr   = bus_wr;
                    pend_slot = s;
                    pend_data = bus_wdata;
                    bus_ready = 1;
                    rdy_pend  = 1;
                end else begin
                    stall--;
                    hold_pend = 1;
                    hold_rd   = bus_rd;
                    hold_wr   = bus_wr;
                    hold_addr = bus_addr;
                end
            end
        end
    end

    task automatic pulse_start();
        @(negedge clk);
        start = 1;
        @(negedge clk);
        start = 0;
    endtask

    task automatic wait_done(output bit ok);
        ok = 0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (done) begin ok = 1; break; end
        end
    endtask

    task automatic close_run(string tag);
        bit ok;
        wait_done(ok);
        chk(ok, "R7", {tag, " done reached before watchdog"}, 32'(ok), 1);
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R5", {tag, " all expected accesses seen"}, exp_q.size(), 0);
        chk(done_cnt == 1, "R8", {tag, " exactly one done pulse"}, done_cnt, 1);
        chk(wait_cyc == 2 * W, "R6", {tag, " pause cycles"}, wait_cyc, 2 * W);
        chk(!busy, "R7", {tag, " idle after run"}, 32'(busy), 0);
    endtask

    initial begin
        mem[0] = 32'h0000_1A5F; mem[1] = 32'hF0F0_0000; mem[2] = 32'h8000_0033;
        sh[0] = mem[0]; sh[1] = mem[1]; sh[2] = mem[2];

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!bus_rd && !bus_wr, "R1", "no strobe in reset", {bus_rd, bus_wr}, 0);
        chk(!busy && !done, "R1", "busy/done low in reset", {busy, done}, 0);
        rst = 0;
        @(negedge clk);
        chk(!bus_rd && !bus_wr && !busy && !done, "R1", "idle after reset",
            {bus_rd, bus_wr, busy, done}, 0);

        // run 1: plain
        push_program();
        done_cnt = 0; wait_cyc = 0;
        @(negedge clk);
        start = 1;
        @(negedge clk);
        start = 0;
        chk(busy, "R2", "busy after start", 32'(busy), 1);
        chk(bus_rd && bus_addr == 32'h200, "R2", "first access reads 0x200", bus_addr, 32'h200);
        close_run("run1");

        // run 2: start pulses while busy
        push_program();
        done_cnt = 0; wait_cyc = 0;
        pulse_start();
        repeat (2) @(negedge clk);
        start = 1;            // during an access (R8)
        @(negedge clk);
        start = 0;
        while (!(busy && !bus_rd && !bus_wr)) @(negedge clk);
        repeat (3) @(negedge clk);
        start = 1;            // during a pause (R8)
        @(negedge clk);
        start = 0;
        close_run("run2");

        chk(both_cnt == 0, "R9", "never both strobes", both_cnt, 0);
        for (int i = 0; i < 3; i++)
            chk(mem[i] == sh[i], "R4", "register contents preserved", mem[i], sh[i]);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%h expected=%h", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule